// File: doc/BRIEF.md
# Block RAM with Sequenced Clear

This block is a simple dual-port memory of 24 words of 18 bits, written in the style that maps onto FPGA block RAM. The storage array has no reset input of its own. A small controller clears it instead. While reset is held, and for the cycles that follow its release, the controller takes over the write port. It writes zero to one location per clock, starting at address 0, until all 24 words are cleared.

A `busy` output is high while the controller owns the write port. During that time, write requests from the user are dropped. When the sequence ends, the write port goes back to the user's enable, address and data. The read side is independent of the write side. It has its own enable and address, and its data output is registered. On a same-address collision it returns the old contents. Accesses to addresses beyond the last word are harmless: a write there stores nothing and a read there returns zero.

Top module: `clrbram`

## Requirements
- R1: While `rst_n` is low, `busy` is 1 and `rd_data` is 0 from the first rising edge of reset onward.
- R2: After `rst_n` rises, `busy` stays high and falls at the 24th rising edge. It never rises again without a new reset.
- R3: After a clear sequence, every address 0 to 23 reads as zero, whatever it held before the reset.
- R4: A user write presented while `busy` is high has no effect on the memory.
- R5: With `busy` low, a rising edge with `wr_en` high and `wr_addr` below 24 stores `wr_data` at `wr_addr`.
- R6: `rd_data` takes the word at `rd_addr` one rising edge after `rd_en` is seen high. On an edge with `rd_en` low, it holds its value.
- R7: A read and a write to the same address on the same edge return the contents from before the write (read-first).
- R8: A user write with `wr_addr` of 24 or more changes no location.
- R9: If `rst_n` falls again during a clear sequence, the sequence restarts at address 0. `busy` then stays high for 24 rising edges after the new release.
- R10: A read with `rd_addr` of 24 or more loads zero into `rd_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset; starts the clear sequence |
| wr_en | input | 1 | User write enable |
| wr_addr | input | 5 | User write address |
| wr_data | input | 18 | User write data |
| rd_en | input | 1 | Read enable |
| rd_addr | input | 5 | Read address |
| rd_data | output | 18 | Registered read data |
| busy | output | 1 | High while the clear sequence owns the write port |

## Verification
On every cycle, the assertions check four things:
- the length of the busy window, measured against a cycle counter started at reset release;
- that busy never rises again on its own;
- that the read register holds whenever read enable is low;
- that out-of-range reads load zero.

Only the bench's scenarios can show the memory contents themselves: that clearing overwrites earlier data, that writes during the clear and writes to out-of-range addresses are dropped, read-first collisions, and a restart of the sequence by a second reset. The bench covers these by sweeping every address against a model of the expected contents.

// File: rtl/clrbram_pkg.sv
// Package: default geometry for the cleared block RAM.
// Assumes DEPTH fits in an address of DEF_AW bits.
package clrbram_pkg;
    localparam int DEF_DEPTH = 24;
    localparam int DEF_WIDTH = 18;
    localparam int DEF_AW    = 5;
endpackage

// File: rtl/clrbram_seq.sv
// Clear sequencer: while reset is low, holds the sweep at address 0 with busy set.
// After release it steps one address per clock and drops busy once the last
// address has been written. Assumes DEPTH >= 1 and DEPTH <= 2**AW.
module clrbram_seq #(
    parameter int DEPTH = 24,
    parameter int AW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          busy,
    output logic [AW-1:0] clr_addr
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    // Sweep state: restart on reset, step until the last word is written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b1;
            clr_addr <= '0;
        end else if (busy) begin
            if (clr_addr == LAST) begin
                busy <= 1'b0;
            end else begin
                clr_addr <= clr_addr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/clrbram_wmux.sv
// Write-port selector: gives the port to the sequencer while busy, otherwise to
// the user. User writes outside 0..DEPTH-1 are masked. Purely combinational.
module clrbram_wmux #(
    parameter int DEPTH = 24,
    parameter int WIDTH = 18,
    parameter int AW    = 5
) (
    input  logic             busy,
    input  logic [AW-1:0]    clr_addr,
    input  logic             usr_en,
    input  logic [AW-1:0]    usr_addr,
    input  logic [WIDTH-1:0] usr_data,
    output logic             mem_we,
    output logic [AW-1:0]    mem_wa,
    output logic [WIDTH-1:0] mem_wd
);
    localparam logic [AW:0] LIMIT = (AW + 1)'(DEPTH);

    logic usr_ok;

    // Range check of the user address.
    always_comb usr_ok = ({1'b0, usr_addr} < LIMIT);

    // Port ownership: the sequencer wins while busy.
    always_comb begin
        if (busy) begin
            mem_we = 1'b1;
            mem_wa = clr_addr;
            mem_wd = '0;
        end else begin
            mem_we = usr_en && usr_ok;
            mem_wa = usr_addr;
            mem_wd = usr_data;
        end
    end
endmodule

// File: rtl/clrbram_array.sv
// Storage: an unreset word array with one synchronous write port and one
// registered read port (read-first). Assumes the write port is range-checked
// upstream; the read port checks its own range and returns zero outside it.
module clrbram_array #(
    parameter int DEPTH = 24,
    parameter int WIDTH = 18,
    parameter int AW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    wa,
    input  logic [WIDTH-1:0] wd,
    input  logic             re,
    input  logic [AW-1:0]    ra,
    output logic [WIDTH-1:0] rq
);
    localparam logic [AW:0] LIMIT = (AW + 1)'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic             ra_ok;

    // Range check of the read address.
    always_comb ra_ok = ({1'b0, ra} < LIMIT);

    // Word write; the array carries no reset.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[wa] <= wd;
        end
    end

    // Output register: loads on enable, holds otherwise, sees pre-write data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq <= '0;
        end else if (re) begin
            rq <= ra_ok ? mem[ra] : '0;
        end
    end
endmodule

// File: rtl/clrbram.sv
// Top: block RAM whose contents are cleared by a write sweep after reset rather
// than by a reset on the array. Assumes a single clock domain.
module clrbram
    import clrbram_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH,
    parameter int WIDTH = DEF_WIDTH,
    parameter int AW    = DEF_AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data,
    output logic             busy
);
    logic [AW-1:0]    clr_addr;
    logic             mem_we;
    logic [AW-1:0]    mem_wa;
    logic [WIDTH-1:0] mem_wd;

    clrbram_seq #(.DEPTH(DEPTH), .AW(AW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .clr_addr (clr_addr)
    );

    clrbram_wmux #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_wmux (
        .busy     (busy),
        .clr_addr (clr_addr),
        .usr_en   (wr_en),
        .usr_addr (wr_addr),
        .usr_data (wr_data),
        .mem_we   (mem_we),
        .mem_wa   (mem_wa),
        .mem_wd   (mem_wd)
    );

    clrbram_array #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .wa    (mem_wa),
        .wd    (mem_wd),
        .re    (rd_en),
        .ra    (rd_addr),
        .rq    (rd_data)
    );
endmodule

// File: rtl/clrbram_chk.sv
// Checker: port-level properties of the cleared block RAM, bound to the top.
// Keeps its own count of cycles since reset release to time the busy window.
module clrbram_chk #(
    parameter int DEPTH = 24,
    parameter int WIDTH = 18,
    parameter int AW    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             rd_en,
    input logic [AW-1:0]    rd_addr,
    input logic [WIDTH-1:0] rd_data
);
    localparam logic [AW:0] LIMIT = (AW + 1)'(DEPTH);

    logic [AW:0] since_rel;

    // Saturating count of edges since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rel <= '0;
        end else if (since_rel < LIMIT) begin
            since_rel <= since_rel + 1'b1;
        end
    end

    // R2: busy spans exactly DEPTH edges after release.
    assert_busy_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy == (since_rel < LIMIT));

    // R2: once low, busy stays low until the next reset.
    assert_busy_no_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !busy);

    // R6: the read register holds on edges without a read enable.
    assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R10: an out-of-range read loads zero.
    assert_rd_oor_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ({1'b0, rd_addr} >= LIMIT)) |=> (rd_data == '0));
endmodule

bind clrbram clrbram_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
);

// File: tb/clrbram_tb.sv
`timescale 1ns/1ps
module clrbram_tb;
    localparam int DEPTH = 24;
    localparam int WIDTH = 18;
    localparam int AW    = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [AW-1:0]    wr_addr = '0;
    logic [WIDTH-1:0] wr_data = '0;
    logic             rd_en = 1'b0;
    logic [AW-1:0]    rd_addr = '0;
    logic [WIDTH-1:0] rd_data;
    logic             busy;

    int n_run = 0;
    int n_fail = 0;
    logic [WIDTH-1:0] model [DEPTH];

    always #2.5 clk = ~clk;

    clrbram u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy)
    );

    function automatic logic [WIDTH-1:0] pat(input int a, input int salt);
        return WIDTH'((a * 7919 + salt * 131 + 3) % (1 << WIDTH));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [WIDTH-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [WIDTH-1:0] q);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = AW'(a);
        @(posedge clk); #1;
        q = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Releases reset and counts edges until busy drops; tries user writes meanwhile.
    task automatic release_and_count(output int n);
        @(negedge clk);
        rst_n = 1'b1;
        n = 0;
        while (n < 100) begin
            @(posedge clk); #1;
            n++;
            if (!busy) break;
            wr_en = 1'b1; wr_addr = AW'(n % DEPTH); wr_data = 18'h2AAAA;
        end
        wr_en = 1'b0;
    endtask

    task automatic sweep_model(input string req);
        logic [WIDTH-1:0] q;
        for (int a = 0; a < DEPTH; a++) begin
            rd(a, q);
            check(q == model[a], req, int'(q), int'(model[a]));
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int n;
        logic [WIDTH-1:0] q;
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check(busy == 1'b1, "R1 busy", int'(busy), 1);
        check(rd_data == '0, "R1 rd_data", int'(rd_data), 0);

        // R2 and R4: busy window with user writes attempted throughout
        release_and_count(n);
        check(n == DEPTH, "R2 busy edges", n, DEPTH);
        repeat (3) @(posedge clk);
        #1;
        check(busy == 1'b0, "R2 stays low", int'(busy), 0);
        for (int a = 0; a < DEPTH; a++) model[a] = '0;
        sweep_model("R3/R4 cleared");

        // R5: fill every address
        for (int a = 0; a < DEPTH; a++) begin
            wr(a, pat(a, 1));
            model[a] = pat(a, 1);
        end
        sweep_model("R5 fill");

        // R8: out-of-range writes
        for (int a = DEPTH; a < (1 << AW); a++) wr(a, pat(a, 9));
        sweep_model("R8 oor write");

        // R6: read latency and hold
        rd(3, q);
        check(q == model[3], "R6 read", int'(q), int'(model[3]));
        @(negedge clk);
        rd_addr = AW'(5);
        @(posedge clk); #1;
        check(rd_data == model[3], "R6 hold", int'(rd_data), int'(model[3]));

        // R7: same-address collision
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(4); wr_data = 18'h15A5A;
        rd_en = 1'b1; rd_addr = AW'(4);
        @(posedge clk); #1;
        check(rd_data == model[4], "R7 old data", int'(rd_data), int'(model[4]));
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        model[4] = 18'h15A5A;
        rd(4, q);
        check(q == model[4], "R7 new data", int'(q), int'(model[4]));

        // R10: out-of-range read
        rd(30, q);
        check(q == '0, "R10 oor read", int'(q), 0);

        // R9: reset interrupting a sweep
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check(busy == 1'b1, "R9 busy in reset", int'(busy), 1);
        check(rd_data == '0, "R1 rd_data again", int'(rd_data), 0);
        release_and_count(n);
        check(n == DEPTH, "R9 restart edges", n, DEPTH);
        for (int a = 0; a < DEPTH; a++) model[a] = '0;
        sweep_model("R3 recleared");

        finish_run();
    end
endmodule